// File: doc/BRIEF.md
# Per-Cell Shift Margin Test Sequencer

This controller measures how far the clock amplitude of a long serial shift register can move before each individual cell stops shifting correctly. The register is driven one clock period at a time. Each period has a positive half and a negative half, and each half's amplitude is set by a signed code. The sequencer loads a sparse pattern of ones at nominal amplitude. It then issues a single probing period in which one half carries a trial amplitude, and unloads the register at nominal amplitude. A tested one that landed exactly one cell further is a pass. A one that stayed put or advanced two cells is a failure.

Ones sit three cells apart, so three offset phases cover every cell. For each phase, each polarity and each side of nominal, the trial amplitude walks away from nominal one step at a time. When tested cells fail at the current step, the failing cell with the lowest index is treated as the weakest. It receives the current code as its limit and its one is cleared, and the same step is tried again. This repeats until the pattern is empty. The four limits of each cell are kept in a small result memory that can be read by cell number. A done level reports that the whole campaign is complete.

Top module: `margin_seq`

## Requirements
- R1: While reset is held and after it is released, done is low, sr_shift is low and every result word reads as zero until a campaign writes it.
- R2: Every shift period carries the nominal code on at least one half. Pattern loading and unloading use nominal codes on both halves. Only one probing period follows each load: the positive half carries the trial code when positive margins are measured, and the negative half carries it when negative margins are measured.
- R3: The register is N+2 cells long; the last two cells are guards that are never tested. A load takes N+2 shift periods and presents the bit for the highest cell first on sr_din. In phase p the pattern holds a one in every cell i < N with i mod 3 = p.
- R4: A tested cell k passes only if, after the probe, its one is read back in cell k+1. A one that stays in cell k, or that reaches cell k+2, is a failure.
- R5: The first trial code of a sweep is nominal plus or minus step, moving away from nominal. It then moves one more step per fault-free trial, for up to span steps (span must be at least 1). Magnitude grows on the high side, so for the negative polarity the high side moves toward more negative codes.
- R6: When one or more tested cells fail, only the failing cell with the lowest index records the current trial code and loses its one. The trial is then repeated at the same code, so a second cell that fails at that code records the same value.
- R7: A tested cell that still passes after the span-th step records the code of that last step.
- R8: Reading cell c returns four signed AW-bit fields: bits [AW-1:0] positive high limit, [2AW-1:AW] positive low limit, [3AW-1:2AW] negative high (largest magnitude) limit, [4AW-1:3AW] negative low limit.
- R9: The campaign runs the positive polarity before the negative one. Within a polarity it runs phases 0, 1, 2, and within a phase the high side before the low side. done then stays high and no shift is issued until start is pulsed again, which clears done on the next cycle and restarts the campaign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse to begin a campaign while idle or done |
| nom_pos | input | AW | Nominal code for the positive half |
| nom_neg | input | AW | Nominal code for the negative half (negative value) |
| step | input | AW | Trial code increment |
| span | input | SW | Number of steps on each side of nominal |
| sr_shift | output | 1 | Register advances one clock period on this edge |
| sr_pos_amp | output | AW | Code for the positive half of the period |
| sr_neg_amp | output | AW | Code for the negative half of the period |
| sr_din | output | 1 | Data bit entering cell 0 |
| sr_dout | input | 1 | Content of the last register cell |
| rd_cell | input | $clog2(N) | Result cell to read |
| rd_data | output | 4*AW | Four limits of the selected cell |
| done | output | 1 | Campaign complete |

## Verification
Two situations can coincide in a single evaluation: several tested cells in the same pattern can fail at the same trial code, and that code can also be the last step of the span. The bench gives two cells of one phase the same high limit, and it gives other cells windows wider than the whole sweep. It then checks that both tied cells read back the identical code, and that the wide cells read back the end-of-range code. A second campaign, started from done with a different step and span, shows that results and done restart cleanly.

// File: rtl/margin_seq.sv
module margin_seq #(
  parameter int N  = 10,
  parameter int AW = 8,
  parameter int SW = 6,
  localparam int CLW = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    nom_pos,
  input  logic [AW-1:0]    nom_neg,
  input  logic [AW-1:0]    step,
  input  logic [SW-1:0]    span,
  output logic             sr_shift,
  output logic [AW-1:0]    sr_pos_amp,
  output logic [AW-1:0]    sr_neg_amp,
  output logic             sr_din,
  input  logic             sr_dout,
  input  logic [CLW-1:0]   rd_cell,
  output logic [4*AW-1:0]  rd_data,
  output logic             done
);
  localparam int LEN = N + 2;
  localparam int CW  = $clog2(LEN);
  localparam logic [3:0] S_IDLE = 4'd0, S_INIT = 4'd1, S_WRITE = 4'd2, S_PROBE = 4'd3,
                         S_READ = 4'd4, S_EVAL = 4'd5, S_FLUSH = 4'd6, S_NEXT = 4'd7,
                         S_DONE = 4'd8;

  logic [3:0]     state;
  logic           pol, side;
  logic [1:0]     phase;
  logic [SW-1:0]  stp;
  logic [AW-1:0]  amp_t;
  logic [N-1:0]   pat;
  logic [LEN-1:0] cap;
  logic [CW-1:0]  cnt;
  logic [AW-1:0]  mem [N][4];

  function automatic logic [N-1:0] stride(input logic [1:0] ph);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = ((i % 3) == int'(ph));
    return m;
  endfunction

  wire          up       = ~(side ^ pol);
  wire [AW-1:0] base     = pol ? nom_neg : nom_pos;
  wire [AW-1:0] delta    = up ? step : AW'(0) - step;
  wire [LEN-1:0] pat_full = {2'b00, pat};
  wire [N-1:0]  first_pat = stride(phase);
  wire [N-1:0]  fvec     = pat & ~cap[N:1];
  wire [N-1:0]  src      = (state == S_FLUSH) ? pat : fvec;
  wire [1:0]    slot     = {pol, side};

  logic [CLW-1:0] pick;
  logic [N-1:0]   pick_oh;
  always_comb begin
    pick    = '0;
    pick_oh = '0;
    for (int i = N - 1; i >= 0; i--)
      if (src[i]) begin
        pick    = CLW'(i);
        pick_oh = N'(1) << i;
      end
  end
  wire [N-1:0] pat_left = pat & ~pick_oh;

  assign sr_shift   = (state == S_WRITE) || (state == S_PROBE) || (state == S_READ);
  assign sr_din     = (state == S_WRITE) && pat_full[CW'(LEN - 1) - cnt];
  assign sr_pos_amp = (state == S_PROBE && !pol) ? amp_t : nom_pos;
  assign sr_neg_amp = (state == S_PROBE &&  pol) ? amp_t : nom_neg;
  assign done       = (state == S_DONE);
  assign rd_data    = {mem[rd_cell][3], mem[rd_cell][2], mem[rd_cell][1], mem[rd_cell][0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      pol   <= 1'b0;
      side  <= 1'b0;
      phase <= 2'd0;
      stp   <= '0;
      amp_t <= '0;
      pat   <= '0;
      cap   <= '0;
      cnt   <= '0;
      for (int c = 0; c < N; c++)
        for (int s = 0; s < 4; s++) mem[c][s] <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE: if (start) begin
          pol   <= 1'b0;
          side  <= 1'b0;
          phase <= 2'd0;
          state <= S_INIT;
        end
        S_INIT: begin
          pat   <= first_pat;
          amp_t <= base + delta;
          stp   <= SW'(1);
          cnt   <= '0;
          state <= (first_pat == '0) ? S_NEXT : S_WRITE;
        end
        S_WRITE: begin
          if (cnt == CW'(LEN - 1)) begin
            cnt   <= '0;
            state <= S_PROBE;
          end else cnt <= cnt + 1'b1;
        end
        S_PROBE: state <= S_READ;
        S_READ: begin
          cap <= {cap[LEN-2:0], sr_dout};
          if (cnt == CW'(LEN - 1)) begin
            cnt   <= '0;
            state <= S_EVAL;
          end else cnt <= cnt + 1'b1;
        end
        S_EVAL: begin
          if (|fvec) begin
            mem[pick][slot] <= amp_t;
            pat   <= pat_left;
            state <= (pat_left == '0) ? S_NEXT : S_WRITE;
          end else if (stp >= span) begin
            state <= S_FLUSH;
          end else begin
            amp_t <= amp_t + delta;
            stp   <= stp + 1'b1;
            state <= S_WRITE;
          end
        end
        S_FLUSH: begin
          if (|pat) begin
            mem[pick][slot] <= amp_t;
            pat <= pat_left;
          end else state <= S_NEXT;
        end
        S_NEXT: begin
          state <= S_INIT;
          if (!side) side <= 1'b1;
          else begin
            side <= 1'b0;
            if (phase != 2'd2) phase <= phase + 1'b1;
            else begin
              phase <= 2'd0;
              if (!pol) pol <= 1'b1;
              else state <= S_DONE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module margin_seq_chk #(
  parameter int N  = 10,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [3:0]    state,
  input logic [N-1:0]  pat,
  input logic          sr_shift,
  input logic [AW-1:0] sr_pos_amp,
  input logic [AW-1:0] sr_neg_amp,
  input logic [AW-1:0] nom_pos,
  input logic [AW-1:0] nom_neg,
  input logic          done
);
  p_one_half_nominal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sr_shift |-> (sr_pos_amp == nom_pos) || (sr_neg_amp == nom_neg));

  p_single_probe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd3) |=> (state == 4'd4));

  p_pattern_never_grows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 4'd1) |=> ((pat & ~$past(pat)) == '0));

  p_one_removal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 4'd1) |=> ($countones(pat) + 1 >= $countones($past(pat))));

  p_done_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_quiet_when_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !sr_shift);
endmodule

bind margin_seq margin_seq_chk #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .state(state), .pat(pat),
  .sr_shift(sr_shift), .sr_pos_amp(sr_pos_amp), .sr_neg_amp(sr_neg_amp),
  .nom_pos(nom_pos), .nom_neg(nom_neg), .done(done));

// File: tb/sim_margin_seq.sv
module sim_margin_seq;
  localparam int N = 10, AW = 8, SW = 6, LEN = N + 2, CLW = $clog2(N);

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] nom_pos, nom_neg, step;
  logic [SW-1:0] span;
  logic sr_shift, sr_din, sr_dout, done;
  logic [AW-1:0] sr_pos_amp, sr_neg_amp;
  logic [CLW-1:0] rd_cell = '0;
  logic [4*AW-1:0] rd_data;

  int checks = 0, errors = 0, runs_checked = 0, run = 0, wcount = 0;
  bit seen_neg = 0, finished = 0;
  int pos_lo[LEN], pos_hi[LEN], neg_lo[LEN], neg_hi[LEN];
  logic reg_q[LEN];
  logic [4*AW-1:0] exp_q[$];

  always #5 clk = ~clk;

  margin_seq #(.N(N), .AW(AW), .SW(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .nom_pos(nom_pos), .nom_neg(nom_neg),
    .step(step), .span(span), .sr_shift(sr_shift), .sr_pos_amp(sr_pos_amp),
    .sr_neg_amp(sr_neg_amp), .sr_din(sr_din), .sr_dout(sr_dout),
    .rd_cell(rd_cell), .rd_data(rd_data), .done(done));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // register model: a one in cell k moves 0, 1 or 2 cells depending on its windows
  function automatic int move(input int k, input int pa, input int na);
    if (pa < pos_lo[k] || -na < neg_lo[k]) return 0;
    if (pa > pos_hi[k] || -na > neg_hi[k]) return 2;
    return 1;
  endfunction

  assign sr_dout = reg_q[LEN-1];

  always @(posedge clk) begin
    if (sr_shift) begin
      logic nq[LEN];
      int pa, na;
      pa = int'($signed(sr_pos_amp));
      na = int'($signed(sr_neg_amp));
      for (int i = 0; i < LEN; i++) nq[i] = 1'b0;
      for (int k = 0; k < LEN; k++)
        if (reg_q[k]) begin
          int d;
          d = k + move(k, pa, na);
          if (d < LEN) nq[d] = 1'b1;
        end
      if (sr_din) nq[0] = 1'b1;
      for (int i = 0; i < LEN; i++) reg_q[i] <= nq[i];
    end
  end

  function automatic int exp_lim(input int c, input int slot, input int np, input int nn,
                                 input int st, input int sp);
    int base, dir, a;
    base = (slot < 2) ? np : nn;
    dir  = (slot == 0 || slot == 3) ? 1 : -1;
    for (int i = 1; i <= sp; i++) begin
      a = base + dir * i * st;
      case (slot)
        0: if (a > pos_hi[c]) return a;
        1: if (a < pos_lo[c]) return a;
        2: if (-a > neg_hi[c]) return a;
        default: if (-a < neg_lo[c]) return a;
      endcase
    end
    return base + dir * sp * st;
  endfunction

  // driver side of the scoreboard
  task automatic push_expected(input int np, input int nn, input int st, input int sp);
    for (int c = 0; c < N; c++) begin
      logic [4*AW-1:0] w;
      for (int s = 0; s < 4; s++) w[s*AW +: AW] = AW'(exp_lim(c, s, np, nn, st, sp));
      exp_q.push_back(w);
    end
  endtask

  // monitor: result memory against queue
  initial forever begin
    @(posedge done);
    @(negedge clk);
    for (int c = 0; c < N; c++) begin
      logic [4*AW-1:0] w;
      string lbl;
      rd_cell = CLW'(c);
      #1;
      w = (exp_q.size() > 0) ? exp_q.pop_front() : '1;
      if (c == 0 || c == 3) lbl = "R6 R8 tied cell";
      else if (c == 9 || c == 4) lbl = "R7 R8 saturated cell";
      else lbl = "R4 R5 R8 cell";
      check(rd_data == w, lbl, rd_data, w);
    end
    runs_checked++;
  end

  // monitor: shift stream
  initial forever begin
    @(negedge clk);
    if (sr_shift) begin
      if (sr_pos_amp != nom_pos && sr_neg_amp != nom_neg) begin
        check(0, "R2 both halves off nominal", sr_pos_amp, nom_pos);
      end
      if (sr_neg_amp != nom_neg) seen_neg = 1;
      if (sr_pos_amp != nom_pos && seen_neg)
        check(0, "R9 positive probe after negative", sr_pos_amp, nom_pos);
      if (run == 1 && wcount < LEN) begin
        int idx;
        logic e;
        idx = LEN - 1 - wcount;
        e = (idx < N) && (idx % 3 == 0);
        check(sr_din == e, "R3 first pattern bit", sr_din, e);
        check(sr_pos_amp == nom_pos && sr_neg_amp == nom_neg, "R2 nominal load", sr_pos_amp, nom_pos);
        wcount++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < LEN; k++) begin
      reg_q[k] = 1'b0;
      pos_hi[k] = 70 + 2 * k;
      pos_lo[k] = 50 - 2 * k;
      neg_hi[k] = 78 - k;
      neg_lo[k] = 44 + k;
    end
    pos_hi[0] = 71; pos_hi[3] = 71;
    pos_hi[9] = 120; neg_lo[4] = 10;
    for (int k = N; k < LEN; k++) begin
      pos_lo[k] = 0; pos_hi[k] = 127; neg_lo[k] = 0; neg_hi[k] = 127;
    end
    nom_pos = 8'(60); nom_neg = 8'(-60); step = 8'd4; span = 6'd8;

    repeat (4) @(negedge clk);
    check(done == 0, "R1 done in reset", done, 0);
    check(sr_shift == 0, "R1 no shift in reset", sr_shift, 0);
    rd_cell = '0; #1;
    check(rd_data == 0, "R1 result cleared", rd_data, 0);
    @(negedge clk);
    rst_n = 1;
    rd_cell = CLW'(N - 1); #1;
    check(rd_data == 0 && done == 0, "R1 after release", rd_data, 0);

    push_expected(60, -60, 4, 8);
    run = 1;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    wait (runs_checked == 1);
    check(wcount == LEN, "R3 load length", wcount, LEN);
    repeat (20) @(negedge clk);
    check(done == 1, "R9 done holds", done, 1);

    nom_pos = 8'(62); nom_neg = 8'(-62); step = 8'd3; span = 6'd5;
    seen_neg = 0;
    push_expected(62, -62, 3, 5);
    run = 2;
    start = 1;
    @(negedge clk); start = 0;
    check(done == 0, "R9 restart clears done", done, 0);
    wait (runs_checked == 2);
    check(exp_q.size() == 0, "R9 all results consumed", exp_q.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule